// File: doc/BRIEF.md
# Parallel-Translation Direct-Mapped Data Cache

This block is a direct-mapped, write-through data cache that is looked up with untranslated address bits. The line index comes only from the page-offset field of the virtual address, so the array read starts in the same cycle as the translation lookaside buffer (TLB) lookup. The cache has no knowledge of virtual page numbers. Each line stores the physical page number it was filled from. The hit decision compares that stored page number with the page number the TLB returns in the same cycle.

Each request produces one registered outcome in the following cycle. There are three outcomes. A hit delivers the word to the processor. A miss with a valid translation asks memory for the line at the translated physical address. A translation miss asks for a full page-table walk, and the cache result is ignored. Writes go to memory in every case. A write that hits also updates the cached word. A separate fill port installs lines that come back from memory.

Top module: `vipt_dcache`

## Requirements
- R1: After reset every line is invalid. No outcome is presented, and the first read of any address with a TLB hit produces a memory outcome.
- R2: The line index is vaddr[11:2]. Bits vaddr[1:0] do not affect which word is returned. The physical address sent out is {tlb_ppn_i, vaddr[11:0]}.
- R3: A read delivers data (rsp_kind_o = 2'd1, rsp_rdata_o = stored word) when three conditions hold together: the TLB hits, the line is valid, and the stored physical page equals tlb_ppn_i.
- R4: A read with a TLB hit on an invalid line gives a memory outcome (rsp_kind_o = 2'd2, mem_req_o = 1, mem_write_o = 0, mem_paddr_o = translated address).
- R5: A request with a TLB miss gives a walk outcome (rsp_kind_o = 2'd3, walk_req_o = 1, walk_vaddr_o = vaddr, mem_req_o = 0).
- R6: The outcome is registered. It appears in the cycle after the request, and rsp_valid_o is low in a cycle after no request.
- R7: A fill at word address fill_paddr_i writes the data, the physical page fill_paddr_i[29:10] and the valid bit at index fill_paddr_i[9:0]. The next read of that physical address hits, including at the last index.
- R8: A write whose line hits replaces the whole cached word with req_wdata_i. It also forwards to memory (rsp_kind_o = 2'd2, mem_write_o = 1, mem_wdata_o = write data).
- R9: A write that misses forwards to memory and allocates no line, so a later read of that address still misses.
- R10: A write with a TLB miss gives a walk outcome and leaves the cached word unchanged.
- R11: A valid line whose stored page differs from tlb_ppn_i is a miss and gives a memory outcome with the new translated address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | Request is a store |
| req_vaddr_i | input | 32 | Virtual byte address |
| req_wdata_i | input | 32 | Store data |
| tlb_hit_i | input | 1 | TLB holds a translation for this request |
| tlb_ppn_i | input | 20 | Physical page number from the TLB |
| fill_valid_i | input | 1 | Install a returned line |
| fill_paddr_i | input | 30 | Physical word address of the returned line |
| fill_data_i | input | 32 | Returned line data |
| rsp_valid_o | output | 1 | Outcome valid |
| rsp_kind_o | output | 2 | 1 deliver, 2 memory, 3 walk |
| rsp_rdata_o | output | 32 | Delivered read data |
| mem_req_o | output | 1 | Memory access requested |
| mem_write_o | output | 1 | Memory access is a store |
| mem_paddr_o | output | 32 | Translated physical byte address |
| mem_wdata_o | output | 32 | Store data for memory |
| walk_req_o | output | 1 | Full translation requested |
| walk_vaddr_o | output | 32 | Virtual address to translate |

## Verification
The assertions assume that the TLB result is settled in the same cycle as req_valid_i. They also assume that a fill never lands on the same index as a store in the same cycle, because in that case the fill takes precedence and the store update is lost. The stimulus meets both assumptions. Each scenario drives one request per cycle with its TLB answer alongside it, and refills are issued only in cycles with no request. The outcome assertions check only what follows one cycle after a sampled request.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    OUT_NONE    = 2'd0,
    OUT_DELIVER = 2'd1,
    OUT_MEMORY  = 2'd2,
    OUT_WALK    = 2'd3
  } outcome_e;
endpackage

// File: rtl/vipt_store.sv
module vipt_store #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (fill_en_i) valid_q[fill_idx_i] <= 1'b1;
  end

  // fill wins over a same-cycle store update
  always_ff @(posedge clk_i) begin
    if (upd_en_i) data_mem[upd_idx_i] <= upd_data_i;
    if (fill_en_i) begin
      data_mem[fill_idx_i] <= fill_data_i;
      tag_mem[fill_idx_i]  <= fill_tag_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_mem[rd_idx_i];
  assign rd_data_o  = data_mem[rd_idx_i];
endmodule

// File: rtl/vipt_decide.sv
module vipt_decide
  import vipt_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic             tlb_hit_i,
  input  logic [TAG_W-1:0] tlb_ppn_i,
  input  logic             line_valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output outcome_e         outcome_o,
  output logic             upd_en_o
);
  logic line_hit;

  assign line_hit = line_valid_i && (line_tag_i == tlb_ppn_i);

  always_comb begin
    if (!req_valid_i)                     outcome_o = OUT_NONE;
    else if (!tlb_hit_i)                  outcome_o = OUT_WALK;
    else if (req_write_i || !line_hit)    outcome_o = OUT_MEMORY;
    else                                  outcome_o = OUT_DELIVER;
  end

  assign upd_en_o = req_valid_i && req_write_i && tlb_hit_i && line_hit;
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int OFS_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic [VPN_W+OFS_W-1:0]   req_vaddr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic                     tlb_hit_i,
  input  logic [PPN_W-1:0]         tlb_ppn_i,
  input  logic                     fill_valid_i,
  input  logic [PPN_W+OFS_W-$clog2(DATA_W/8)-1:0] fill_paddr_i,
  input  logic [DATA_W-1:0]        fill_data_i,
  output logic                     rsp_valid_o,
  output logic [1:0]               rsp_kind_o,
  output logic [DATA_W-1:0]        rsp_rdata_o,
  output logic                     mem_req_o,
  output logic                     mem_write_o,
  output logic [PPN_W+OFS_W-1:0]   mem_paddr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  output logic                     walk_req_o,
  output logic [VPN_W+OFS_W-1:0]   walk_vaddr_o
);
  localparam int VA_W   = VPN_W + OFS_W;
  localparam int PA_W   = PPN_W + OFS_W;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int IDX_W  = OFS_W - BYTE_W;

  logic [IDX_W-1:0]  req_idx;
  logic              line_valid;
  logic [PPN_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data;
  outcome_e          outcome_d;
  logic              upd_en;

  // index from page offset only: read overlaps translation
  assign req_idx = req_vaddr_i[OFS_W-1:BYTE_W];

  vipt_store #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (req_idx),
    .rd_valid_o  (line_valid),
    .rd_tag_o    (line_tag),
    .rd_data_o   (line_data),
    .upd_en_i    (upd_en),
    .upd_idx_i   (req_idx),
    .upd_data_i  (req_wdata_i),
    .fill_en_i   (fill_valid_i),
    .fill_idx_i  (fill_paddr_i[IDX_W-1:0]),
    .fill_tag_i  (fill_paddr_i[IDX_W+PPN_W-1:IDX_W]),
    .fill_data_i (fill_data_i)
  );

  vipt_decide #(.TAG_W(PPN_W)) u_decide (
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .tlb_hit_i    (tlb_hit_i),
    .tlb_ppn_i    (tlb_ppn_i),
    .line_valid_i (line_valid),
    .line_tag_i   (line_tag),
    .outcome_o    (outcome_d),
    .upd_en_o     (upd_en)
  );

  outcome_e          kind_q;
  logic              write_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PA_W-1:0]   paddr_q;
  logic [VA_W-1:0]   vaddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= OUT_NONE;
      write_q <= 1'b0;
      rdata_q <= '0;
      wdata_q <= '0;
      paddr_q <= '0;
      vaddr_q <= '0;
    end else begin
      kind_q <= outcome_d;
      if (req_valid_i) begin
        write_q <= req_write_i;
        rdata_q <= line_data;
        wdata_q <= req_wdata_i;
        paddr_q <= {tlb_ppn_i, req_vaddr_i[OFS_W-1:0]};
        vaddr_q <= req_vaddr_i;
      end
    end
  end

  assign rsp_valid_o  = (kind_q != OUT_NONE);
  assign rsp_kind_o   = kind_q;
  assign rsp_rdata_o  = rdata_q;
  assign mem_req_o    = (kind_q == OUT_MEMORY);
  assign mem_write_o  = write_q;
  assign mem_paddr_o  = paddr_q;
  assign mem_wdata_o  = wdata_q;
  assign walk_req_o   = (kind_q == OUT_WALK);
  assign walk_vaddr_o = vaddr_q;

  // R5
  tlb_miss_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !tlb_hit_i) |=> (walk_req_o && !mem_req_o));

  // R6
  idle_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R8
  store_forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && tlb_hit_i) |=> (mem_req_o && mem_write_o));

  // R2
  paddr_compose_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && tlb_hit_i) |=>
      (mem_paddr_o == {$past(tlb_ppn_i), $past(req_vaddr_i[OFS_W-1:0])}));

  // R3
  deliver_needs_tlb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 2'd1) |-> ($past(tlb_hit_i) && !$past(req_write_i)));

  // R4
  outcome_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, walk_req_o, rsp_kind_o == 2'd1}));
endmodule

// File: tb/vipt_dcache_tb.sv
`timescale 1ns/1ps
module vipt_dcache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_wdata = '0;
  logic        tlb_hit = 1'b0;
  logic [19:0] tlb_ppn = '0;
  logic        fill_valid = 1'b0;
  logic [29:0] fill_paddr = '0;
  logic [31:0] fill_data = '0;
  logic        rsp_valid, mem_req, mem_write, walk_req;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_rdata, mem_paddr, mem_wdata, walk_vaddr;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vipt_dcache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_vaddr_i(req_vaddr), .req_wdata_i(req_wdata),
    .tlb_hit_i(tlb_hit), .tlb_ppn_i(tlb_ppn),
    .fill_valid_i(fill_valid), .fill_paddr_i(fill_paddr), .fill_data_i(fill_data),
    .rsp_valid_o(rsp_valid), .rsp_kind_o(rsp_kind), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_write_o(mem_write), .mem_paddr_o(mem_paddr),
    .mem_wdata_o(mem_wdata), .walk_req_o(walk_req), .walk_vaddr_o(walk_vaddr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request; returns at the next negedge with the outcome visible
  task automatic access(input logic wr, input logic [31:0] va, input logic [31:0] wd,
                        input logic hit, input logic [19:0] ppn);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_vaddr = va; req_wdata = wd;
    tlb_hit = hit; tlb_ppn = ppn;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tlb_hit = 1'b0;
  endtask

  task automatic refill(input logic [31:0] pa, input logic [31:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_paddr = pa[31:2]; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rsp_valid after reset", rsp_valid, 0);
    check("R1 mem_req after reset", mem_req, 0);
    check("R1 walk_req after reset", walk_req, 0);
  endtask

  task automatic t_cold_miss;
    access(1'b0, 32'h0ABC_D234, 0, 1'b1, 20'h12345);
    check("R1 cold read kind", rsp_kind, 2);
    check("R4 mem_req", mem_req, 1);
    check("R4 mem_write", mem_write, 0);
    check("R2 paddr", mem_paddr, 32'h1234_5234);
    check("R6 rsp_valid one cycle later", rsp_valid, 1);
  endtask

  task automatic t_fill_hit;
    refill(32'h1234_5234, 32'hDEAD_BEEF);
    access(1'b0, 32'h0ABC_D234, 0, 1'b1, 20'h12345);
    check("R7 hit after fill kind", rsp_kind, 1);
    check("R3 delivered data", rsp_rdata, 32'hDEAD_BEEF);
    access(1'b0, 32'h0ABC_D237, 0, 1'b1, 20'h12345);
    check("R2 byte bits ignored kind", rsp_kind, 1);
    check("R2 byte bits ignored data", rsp_rdata, 32'hDEAD_BEEF);
    refill(32'h0007_7FFC, 32'h5A5A_A5A5);
    access(1'b0, 32'h4440_0FFC, 0, 1'b1, 20'h00077);
    check("R7 last index kind", rsp_kind, 1);
    check("R7 last index data", rsp_rdata, 32'h5A5A_A5A5);
  endtask

  task automatic t_alias;
    access(1'b0, 32'h0ABC_D234, 0, 1'b1, 20'h54321);
    check("R11 tag mismatch kind", rsp_kind, 2);
    check("R11 tag mismatch paddr", mem_paddr, 32'h5432_1234);
  endtask

  task automatic t_tlb_miss;
    access(1'b0, 32'h0ABC_D234, 0, 1'b0, 20'h12345);
    check("R5 walk kind", rsp_kind, 3);
    check("R5 walk_req", walk_req, 1);
    check("R5 no mem_req", mem_req, 0);
    check("R5 walk vaddr", walk_vaddr, 32'h0ABC_D234);
  endtask

  task automatic t_write_hit;
    access(1'b1, 32'h0ABC_D234, 32'h1122_3344, 1'b1, 20'h12345);
    check("R8 write kind", rsp_kind, 2);
    check("R8 mem_write", mem_write, 1);
    check("R8 mem_wdata", mem_wdata, 32'h1122_3344);
    access(1'b0, 32'h0ABC_D234, 0, 1'b1, 20'h12345);
    check("R8 updated word kind", rsp_kind, 1);
    check("R8 updated word data", rsp_rdata, 32'h1122_3344);
  endtask

  task automatic t_write_miss;
    access(1'b1, 32'h0000_0100, 32'h0BAD_F00D, 1'b1, 20'h00777);
    check("R9 write miss mem_write", mem_write, 1);
    check("R9 write miss paddr", mem_paddr, 32'h0077_7100);
    access(1'b0, 32'h0000_0100, 0, 1'b1, 20'h00777);
    check("R9 no allocate kind", rsp_kind, 2);
  endtask

  task automatic t_write_tlb_miss;
    access(1'b1, 32'h0ABC_D234, 32'hCAFE_F00D, 1'b0, 20'h12345);
    check("R10 write tlb miss kind", rsp_kind, 3);
    access(1'b0, 32'h0ABC_D234, 0, 1'b1, 20'h12345);
    check("R10 word unchanged", rsp_rdata, 32'h1122_3344);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check("R6 idle no rsp", rsp_valid, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cold_miss();
    t_fill_hit();
    t_alias();
    t_tlb_miss();
    t_write_hit();
    t_write_miss();
    t_write_tlb_miss();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule